// File: doc/BRIEF.md
# Reversible Gate Cascade Evaluator

This block stores a programmable list of reversible gates and runs an n-wire bit vector through that list. Each list entry names one target wire and one of two gate kinds. The first kind is a plain inverter on the target wire. The second is a fully controlled inverter: it inverts the target only when every other wire carries 1.

Software, or a neighbouring block, fills the list through a write port and sets the active length. A single-cycle start then hands in the input vector. The evaluator applies one gate per clock, beginning with entry 0, and pulses a done strobe with the permuted vector once the last active entry has been applied. No extra ancilla wires are used, and the wire count is a parameter of at least 3.

Top module: `rgc_cascade`

## Requirements
- R1: An entry with kind bit 0 (`cfg_gate_ctl`=0) inverts bit `tgt` of the vector and leaves every other bit unchanged.
- R2: An entry with kind bit 1 (`cfg_gate_ctl`=1) inverts bit `tgt` only when all other WIDTH-1 bits are 1. Otherwise the whole vector passes unchanged.
- R3: Entries are applied in ascending index order, starting at entry 0, with one entry per clock. If a start is sampled at edge E and the length is L ≥ 1, `out_valid` is high for exactly one cycle after edge E+L. Between consecutive clocks during a run, at most one output bit changes.
- R4: With a length of 0, a start returns the input vector unchanged, with `out_valid` high in the cycle right after the start edge. `busy` stays low.
- R5: An entry whose target index is WIDTH or greater leaves the vector unchanged, whatever its kind.
- R6: `busy` rises only after a start is accepted and stays high until the edge that raises `out_valid`. It is never high together with `out_valid`. A start sampled while `busy` is high is ignored and produces no extra result.
- R7: A length write above DEPTH is stored as DEPTH.
- R8: Writes to the gate list and to the length register are ignored while `busy` is high.
- R9: After reset, `busy` and `out_valid` are 0, `out_vec` is 0 and the length is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_gate_we | input | 1 | Write strobe for one list entry |
| cfg_gate_idx | input | $clog2(DEPTH) | Entry index to write |
| cfg_gate_ctl | input | 1 | Entry kind: 0 plain inverter, 1 fully controlled inverter |
| cfg_gate_tgt | input | $clog2(WIDTH) | Target wire of the entry |
| cfg_len_we | input | 1 | Write strobe for the active length |
| cfg_len | input | $clog2(DEPTH+1) | Number of entries to apply |
| in_valid | input | 1 | Start strobe; samples `in_vec` |
| in_vec | input | WIDTH | Input vector |
| busy | output | 1 | Cascade in progress |
| out_valid | output | 1 | One-cycle strobe marking a finished result |
| out_vec | output | WIDTH | Permuted vector |

## Verification
The hardest situations to reach from the ports involve events that land in the middle of a run. These are a second start and writes to the list or the length, all of which must leave no trace. The bench raises a second start with a different vector on the cycle after the first is accepted. It also rewrites the length and entry 0 while `busy` is high, then reruns the same list to show that neither change took hold. The length clamp needs every one of the DEPTH entries filled: the bench loads a full list whose parity leaves a known signature, then checks both the result and the exact run length.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
    typedef enum logic {
        GATE_NOT  = 1'b0,
        GATE_CNOT = 1'b1
    } gate_kind_e;
endpackage

// File: rtl/rgc_gate_store.sv
module rgc_gate_store
    import rgc_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int TGT_W = 3,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  gate_kind_e       wr_kind,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic [IDX_W-1:0] rd_idx,
    output gate_kind_e       rd_kind,
    output logic [TGT_W-1:0] rd_tgt
);
    logic [DEPTH-1:0] kind_d, kind_q;
    logic [TGT_W-1:0] tgt_d [DEPTH];
    logic [TGT_W-1:0] tgt_q [DEPTH];

    always_comb begin
        kind_d = kind_q;
        for (int i = 0; i < DEPTH; i++) begin
            tgt_d[i] = tgt_q[i];
        end
        if (wr_en) begin
            kind_d[wr_idx] = wr_kind;
            tgt_d[wr_idx]  = wr_tgt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tgt_q[i] <= '0;
            end
        end else begin
            kind_q <= kind_d;
            for (int i = 0; i < DEPTH; i++) begin
                tgt_q[i] <= tgt_d[i];
            end
        end
    end

    assign rd_kind = gate_kind_e'(kind_q[rd_idx]);
    assign rd_tgt  = tgt_q[rd_idx];
endmodule

// File: rtl/rgc_gate_apply.sv
module rgc_gate_apply
    import rgc_pkg::*;
#(
    parameter int WIDTH = 5,
    parameter int TGT_W = 3
) (
    input  logic [WIDTH-1:0] vec_i,
    input  gate_kind_e       kind_i,
    input  logic [TGT_W-1:0] tgt_i,
    output logic [WIDTH-1:0] vec_o
);
    for (genvar w = 0; w < WIDTH; w++) begin : g_wire
        logic others_set;
        logic is_target;
        logic flip;
        assign others_set = &(vec_i | (WIDTH'(1) << w));
        assign is_target  = (tgt_i == TGT_W'(w));
        assign flip       = is_target && ((kind_i == GATE_NOT) || others_set);
        assign vec_o[w]   = vec_i[w] ^ flip;
    end
endmodule

// File: rtl/rgc_cascade.sv
module rgc_cascade
    import rgc_pkg::*;
#(
    parameter int WIDTH = 5,
    parameter int DEPTH = 64,
    localparam int TGT_W = $clog2(WIDTH),
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_gate_we,
    input  logic [IDX_W-1:0] cfg_gate_idx,
    input  logic             cfg_gate_ctl,
    input  logic [TGT_W-1:0] cfg_gate_tgt,
    input  logic             cfg_len_we,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_vec,
    output logic             busy,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_vec
);
    typedef struct packed {
        logic             run;
        logic             done;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [WIDTH-1:0] vec;
    } state_t;

    state_t q, d;

    gate_kind_e       cur_kind;
    logic [TGT_W-1:0] cur_tgt;
    logic [WIDTH-1:0] applied_vec;
    logic [LEN_W-1:0] cnt_nx;
    logic [LEN_W-1:0] len_cur;
    logic [LEN_W-1:0] cnt_cur;

    rgc_gate_store #(.DEPTH(DEPTH), .TGT_W(TGT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_gate_we && !q.run),
        .wr_idx  (cfg_gate_idx),
        .wr_kind (gate_kind_e'(cfg_gate_ctl)),
        .wr_tgt  (cfg_gate_tgt),
        .rd_idx  (q.cnt[IDX_W-1:0]),
        .rd_kind (cur_kind),
        .rd_tgt  (cur_tgt)
    );

    rgc_gate_apply #(.WIDTH(WIDTH), .TGT_W(TGT_W)) u_apply (
        .vec_i  (q.vec),
        .kind_i (cur_kind),
        .tgt_i  (cur_tgt),
        .vec_o  (applied_vec)
    );

    assign cnt_nx = q.cnt + LEN_W'(1);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (cfg_len_we && !q.run) begin
            d.len = (cfg_len > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : cfg_len;
        end
        if (q.run) begin
            d.vec = applied_vec;
            d.cnt = cnt_nx;
            if (cnt_nx == q.len) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end else if (in_valid) begin
            d.vec = in_vec;
            d.cnt = '0;
            if (q.len == '0) begin
                d.done = 1'b1;
            end else begin
                d.run = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = q.run;
    assign out_valid = q.done;
    assign out_vec   = q.vec;
    assign len_cur   = q.len;
    assign cnt_cur   = q.cnt;
endmodule

// File: rtl/rgc_cascade_chk.sv
module rgc_cascade_chk #(
    parameter int WIDTH = 5,
    parameter int DEPTH = 64,
    parameter int LEN_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             busy,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_vec,
    input logic [LEN_W-1:0] len_cur,
    input logic [LEN_W-1:0] cnt_cur
);
    a_r6_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || out_valid));

    a_r6_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_valid));

    a_r6_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && out_valid));

    a_r3_one_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($countones(out_vec ^ $past(out_vec)) <= 1));

    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_cur < len_cur));

    a_r7_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
        len_cur <= LEN_W'(DEPTH));

    a_r8_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(len_cur));

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !in_valid) |=> $stable(out_vec));
endmodule

bind rgc_cascade rgc_cascade_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .busy      (busy),
    .out_valid (out_valid),
    .out_vec   (out_vec),
    .len_cur   (len_cur),
    .cnt_cur   (cnt_cur)
);

// File: tb/rgc_cascade_tb.sv
module rgc_cascade_tb;
    localparam int W  = 5;
    localparam int D  = 64;
    localparam int TW = $clog2(W);
    localparam int IW = $clog2(D);
    localparam int LW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_gate_we = 1'b0;
    logic [IW-1:0] cfg_gate_idx = '0;
    logic          cfg_gate_ctl = 1'b0;
    logic [TW-1:0] cfg_gate_tgt = '0;
    logic          cfg_len_we = 1'b0;
    logic [LW-1:0] cfg_len = '0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_vec = '0;
    logic          busy, out_valid;
    logic [W-1:0]  out_vec;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    rgc_cascade #(.WIDTH(W), .DEPTH(D)) u_dut (.*);

    // behavioural reference model
    int m_kind [D];
    int m_tgt  [D];
    int m_len = 0, m_cnt = 0;
    bit m_busy = 0, m_done = 0;
    int m_vec = 0;

    function automatic int apply_gate(int v, int kind, int tgt);
        bit all_others = 1;
        if (tgt >= W) return v;
        for (int b = 0; b < W; b++) begin
            if (b != tgt && v[b] == 1'b0) all_others = 0;
        end
        if (kind == 0 || all_others) v[tgt] = ~v[tgt];
        return v;
    endfunction

    initial begin
        for (int i = 0; i < D; i++) begin
            m_kind[i] = 0;
            m_tgt[i]  = 0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_len = 0; m_cnt = 0; m_busy = 0; m_done = 0; m_vec = 0;
        end else begin
            automatic bit was_busy = m_busy;
            m_done = 0;
            if (was_busy) begin
                m_vec = apply_gate(m_vec, m_kind[m_cnt], m_tgt[m_cnt]);
                m_cnt++;
                if (m_cnt == m_len) begin
                    m_busy = 0;
                    m_done = 1;
                end
            end else if (in_valid) begin
                m_vec = int'(in_vec);
                m_cnt = 0;
                if (m_len == 0) m_done = 1;
                else m_busy = 1;
            end
            if (!was_busy && cfg_gate_we) begin
                m_kind[cfg_gate_idx] = int'(cfg_gate_ctl);
                m_tgt[cfg_gate_idx]  = int'(cfg_gate_tgt);
            end
            if (!was_busy && cfg_len_we) begin
                m_len = (int'(cfg_len) > D) ? D : int'(cfg_len);
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model (R3 R6 timing and values)
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_busy, "R6 model busy", int'(busy), int'(m_busy));
            chk(out_valid == m_done, "R3 model out_valid", int'(out_valid), int'(m_done));
            if (m_done) chk(int'(out_vec) == m_vec, "R3 model out_vec", int'(out_vec), m_vec);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wgate(int idx, int kind, int tgt);
        @(negedge clk);
        cfg_gate_we  = 1'b1;
        cfg_gate_idx = IW'(idx);
        cfg_gate_ctl = kind[0];
        cfg_gate_tgt = TW'(tgt);
        @(negedge clk);
        cfg_gate_we = 1'b0;
    endtask

    task automatic wlen(int len);
        @(negedge clk);
        cfg_len_we = 1'b1;
        cfg_len    = LW'(len);
        @(negedge clk);
        cfg_len_we = 1'b0;
    endtask

    task automatic run(int vec, int exp, int exp_lat, string tag);
        int lat = 0;
        @(negedge clk);
        in_valid = 1'b1;
        in_vec   = W'(vec);
        @(negedge clk);
        in_valid = 1'b0;
        while (!out_valid && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        chk(int'(out_vec) == exp, tag, int'(out_vec), exp);
        if (exp_lat >= 0) chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(busy == 1'b0, "R9 busy", int'(busy), 0);
        chk(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
        chk(out_vec == '0, "R9 out_vec", int'(out_vec), 0);
        rst_n = 1'b1;
        // R9: length is 0 after reset, so a start returns at once
        run('h0d, 'h0d, 0, "R9 length zero after reset");

        // R4: zero length passes input through
        wlen(0);
        run('h16, 'h16, 0, "R4 zero length");

        // R1: plain inverter
        wgate(0, 0, 2); wlen(1);
        run('h00, 'h04, 1, "R1 not wire2 on 0");
        run('h1f, 'h1b, 1, "R1 not wire2 on 1f");

        // R2: fully controlled inverter on wire 0
        wgate(0, 1, 0);
        run('h1e, 'h1f, 1, "R2 cnot all set");
        run('h16, 'h16, 1, "R2 cnot control clear");
        run('h1f, 'h1e, 1, "R2 cnot clears target");

        // R5: out-of-range targets
        wgate(0, 0, 6);
        run('h15, 'h15, 1, "R5 not tgt6");
        wgate(0, 1, 7);
        run('h1e, 'h1e, 1, "R5 cnot tgt7");

        // R3: order matters
        wgate(0, 0, 0); wgate(1, 1, 1); wlen(2);
        run('h1c, 'h1f, 2, "R3 not0 then cnot1");
        wgate(0, 1, 1); wgate(1, 0, 0);
        run('h1c, 'h1d, 2, "R3 cnot1 then not0");

        // R6: second start during a run is ignored
        wgate(0, 0, 0); wgate(1, 0, 1); wgate(2, 0, 2); wlen(3);
        @(negedge clk);
        in_valid = 1'b1; in_vec = W'('h00);
        @(negedge clk);
        in_vec = W'('h1f);
        chk(busy == 1'b1, "R6 busy after start", int'(busy), 1);
        @(negedge clk);
        in_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        chk(int'(out_vec) == 'h07, "R6 first start wins", int'(out_vec), 'h07);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(!out_valid && !busy, "R6 no extra result", int'(out_valid), 0);
        end

        // R8: writes during a run are dropped
        @(negedge clk);
        in_valid = 1'b1; in_vec = W'('h00);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_len_we = 1'b1; cfg_len = '0;
        cfg_gate_we = 1'b1; cfg_gate_idx = '0; cfg_gate_ctl = 1'b0; cfg_gate_tgt = TW'(4);
        @(negedge clk);
        cfg_len_we = 1'b0; cfg_gate_we = 1'b0;
        while (!out_valid) @(negedge clk);
        run('h00, 'h07, 3, "R8 list and length kept");

        // R7: length above depth clamps to depth
        for (int i = 0; i < D - 1; i++) wgate(i, 0, 0);
        wgate(D - 1, 0, 3);
        wlen(100);
        run('h00, 'h09, D, "R7 clamp to depth");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule